// File: doc/BRIEF.md
# Windowed Page Translator with Physical Region Decode

This block maps the 16-bit logical address of an 8-bit CPU onto a 21-bit physical address space. The logical space is cut into eight 8 KB windows. Each window has its own 8-bit page register, and the register chosen by the top three logical address bits supplies the upper eight bits of the physical address. The low 13 bits pass through unchanged. The CPU core loads a page register from its accumulator through a write strobe, a register index and a data byte. It reads a register back through the same index.

The translated page number is then decoded into one-hot region selects: cartridge ROM, low expansion, working RAM, high expansion and memory-mapped I/O. Three pages belong to no region. They raise an open-bus flag instead of any select. The physical address and the selects are registered together, so both describe the same bus cycle, one clock after the logical address is presented. Logical `$2000-$21FF`, which holds the CPU's zero page and stack, is reached through page register 1 like any other part of window 1.

Top module: `page_mmu`

## Requirements
- R1: `phys_addr[12:0]` equals the `log_addr[12:0]` presented one clock earlier.
- R2: `phys_addr[20:13]` equals the page register selected by `log_addr[15:13]` in the cycle the address was presented, one clock earlier.
- R3: When `map_wr_en` is high at a clock edge, page register `map_idx` takes `map_wr_data`. An address presented in that same cycle still translates through the old value, and the new value is used from the next cycle onward. No other register changes.
- R4: `map_rd_data` shows, one clock later, the page register named by `map_idx`, as it held before that edge. A write in the same cycle returns the old value, and the next cycle returns the new one.
- R5: While `rst` is high at a clock edge, every page register is cleared to `$00` and `phys_addr`, `map_rd_data`, `region_sel` and `open_bus` are cleared to zero. After reset, every window translates to page `$00`, so the reset vector at logical `$FFFx` comes from the first cartridge page.
- R6: Pages `$00-$7F` assert only `region_sel[0]` (cartridge).
- R7: Pages `$80-$F7` assert only `region_sel[1]` (low expansion).
- R8: Page `$F8` asserts only `region_sel[2]` (working RAM).
- R9: Pages `$F9-$FB` assert only `region_sel[3]` (high expansion).
- R10: Page `$FF` asserts only `region_sel[4]` (I/O registers).
- R11: Pages `$FC-$FE` leave `region_sel` at zero and raise `open_bus`.
- R12: From the second clock after reset is released, exactly one of `{open_bus, region_sel}` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| log_addr | input | 16 | Logical address from the CPU |
| map_wr_en | input | 1 | Load strobe for the page register named by `map_idx` |
| map_idx | input | 3 | Page register index used for both write and read-back |
| map_wr_data | input | 8 | New page number (the accumulator value) |
| map_rd_data | output | 8 | Registered read-back of page register `map_idx` |
| phys_addr | output | 21 | Registered physical address |
| region_sel | output | 5 | One-hot region select: [0] cartridge, [1] low expansion, [2] working RAM, [3] high expansion, [4] I/O |
| open_bus | output | 1 | Registered flag for an unmapped physical page |

## Verification
A corrupted page register cannot hide. It shows as a wrong upper `phys_addr` byte one clock after any address in its window is presented, and as a wrong `map_rd_data` one clock after its index is named. A mis-ordered write is caught in the first cycle after the strobe, because that cycle must still show the old page and the following cycle the new one. A wrong region boundary shows in the same registered cycle as the page that crosses it, so the bench places pages on both sides of every boundary.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

  // Region codes; the numeric value is the bit position in region_sel.
  typedef enum logic [2:0] {
    RGN_CART   = 3'd0,
    RGN_EXP_LO = 3'd1,
    RGN_WRAM   = 3'd2,
    RGN_EXP_HI = 3'd3,
    RGN_IO     = 3'd4,
    RGN_NONE   = 3'd5
  } region_e;

  localparam int NUM_SEL = 5;

endpackage

// File: rtl/mmu_page_regs.sv
module mmu_page_regs #(
  parameter int              PAGE_W     = 8,
  parameter int              WIN_W      = 3,
  parameter logic [PAGE_W-1:0] RESET_PAGE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WIN_W-1:0]  wr_idx,
  input  logic [PAGE_W-1:0] wr_data,
  input  logic [WIN_W-1:0]  xl_idx,
  output logic [PAGE_W-1:0] xl_page,
  input  logic [WIN_W-1:0]  rd_idx,
  output logic [PAGE_W-1:0] rd_page
);

  localparam int NUM_WIN = 1 << WIN_W;

  logic [PAGE_W-1:0] page_q [NUM_WIN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WIN; i++) page_q[i] <= RESET_PAGE;
    end else if (wr_en) begin
      page_q[wr_idx] <= wr_data;
    end
  end

  assign xl_page = page_q[xl_idx];
  assign rd_page = page_q[rd_idx];

  // A loaded value must be the one held after the edge.
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> page_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/mmu_region_decode.sv
module mmu_region_decode
  import mmu_pkg::*;
#(
  parameter int                PAGE_W       = 8,
  parameter logic [PAGE_W-1:0] CART_LAST    = 8'h7F,
  parameter logic [PAGE_W-1:0] EXP_LO_LAST  = 8'hF7,
  parameter logic [PAGE_W-1:0] WRAM_PAGE    = 8'hF8,
  parameter logic [PAGE_W-1:0] EXP_HI_FIRST = 8'hF9,
  parameter logic [PAGE_W-1:0] EXP_HI_LAST  = 8'hFB,
  parameter logic [PAGE_W-1:0] IO_PAGE      = 8'hFF
) (
  input  logic [PAGE_W-1:0] page,
  output region_e           region
);

  always_comb begin
    if (page <= CART_LAST)
      region = RGN_CART;
    else if (page <= EXP_LO_LAST)
      region = RGN_EXP_LO;
    else if (page == WRAM_PAGE)
      region = RGN_WRAM;
    else if (page >= EXP_HI_FIRST && page <= EXP_HI_LAST)
      region = RGN_EXP_HI;
    else if (page == IO_PAGE)
      region = RGN_IO;
    else
      region = RGN_NONE;
  end

endmodule

// File: rtl/mmu_out_stage.sv
module mmu_out_stage
  import mmu_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PAGE_W-1:0]        page_d,
  input  logic [OFF_W-1:0]         off_d,
  input  region_e                  region_d,
  output logic [PAGE_W+OFF_W-1:0]  phys_q,
  output logic [NUM_SEL-1:0]       sel_q,
  output logic                     open_q
);

  logic [NUM_SEL-1:0] sel_d;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    assign sel_d[g] = (region_d == region_e'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_q <= '0;
      sel_q  <= '0;
      open_q <= 1'b0;
    end else begin
      phys_q <= {page_d, off_d};
      sel_q  <= sel_d;
      open_q <= (region_d == RGN_NONE);
    end
  end

endmodule

// File: rtl/page_mmu.sv
module page_mmu
  import mmu_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 13,
  parameter int WIN_W  = 3,
  parameter logic [PAGE_W-1:0] CART_LAST    = 8'h7F,
  parameter logic [PAGE_W-1:0] EXP_LO_LAST  = 8'hF7,
  parameter logic [PAGE_W-1:0] WRAM_PAGE    = 8'hF8,
  parameter logic [PAGE_W-1:0] EXP_HI_FIRST = 8'hF9,
  parameter logic [PAGE_W-1:0] EXP_HI_LAST  = 8'hFB,
  parameter logic [PAGE_W-1:0] IO_PAGE      = 8'hFF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [WIN_W+OFF_W-1:0]    log_addr,
  input  logic                      map_wr_en,
  input  logic [WIN_W-1:0]          map_idx,
  input  logic [PAGE_W-1:0]         map_wr_data,
  output logic [PAGE_W-1:0]         map_rd_data,
  output logic [PAGE_W+OFF_W-1:0]   phys_addr,
  output logic [NUM_SEL-1:0]        region_sel,
  output logic                      open_bus
);

  localparam int LOG_W  = WIN_W + OFF_W;
  localparam int PHYS_W = PAGE_W + OFF_W;

  logic [PAGE_W-1:0] xl_page;
  logic [PAGE_W-1:0] rd_page;
  region_e           region;
  logic              primed;

  mmu_page_regs #(
    .PAGE_W     (PAGE_W),
    .WIN_W      (WIN_W),
    .RESET_PAGE ('0)
  ) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (map_wr_en),
    .wr_idx  (map_idx),
    .wr_data (map_wr_data),
    .xl_idx  (log_addr[LOG_W-1 -: WIN_W]),
    .xl_page (xl_page),
    .rd_idx  (map_idx),
    .rd_page (rd_page)
  );

  mmu_region_decode #(
    .PAGE_W       (PAGE_W),
    .CART_LAST    (CART_LAST),
    .EXP_LO_LAST  (EXP_LO_LAST),
    .WRAM_PAGE    (WRAM_PAGE),
    .EXP_HI_FIRST (EXP_HI_FIRST),
    .EXP_HI_LAST  (EXP_HI_LAST),
    .IO_PAGE      (IO_PAGE)
  ) dec_i (
    .page   (xl_page),
    .region (region)
  );

  mmu_out_stage #(
    .PAGE_W (PAGE_W),
    .OFF_W  (OFF_W)
  ) out_i (
    .clk      (clk),
    .rst      (rst),
    .page_d   (xl_page),
    .off_d    (log_addr[OFF_W-1:0]),
    .region_d (region),
    .phys_q   (phys_addr),
    .sel_q    (region_sel),
    .open_q   (open_bus)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      map_rd_data <= '0;
      primed      <= 1'b0;
    end else begin
      map_rd_data <= rd_page;
      primed      <= 1'b1;
    end
  end

  // Offset bits pass straight through with one cycle of latency.
  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
    primed |-> phys_addr[OFF_W-1:0] == $past(log_addr[OFF_W-1:0]));

  // The output registers come out of reset cleared.
  assert_reset_clear_R5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (phys_addr == '0 && region_sel == '0 && !open_bus));

  assert_wram_page_R8: assert property (@(posedge clk) disable iff (rst)
    (primed && phys_addr[PHYS_W-1 -: PAGE_W] == WRAM_PAGE)
      |-> region_sel == NUM_SEL'(1 << RGN_WRAM));

  assert_io_page_R10: assert property (@(posedge clk) disable iff (rst)
    (primed && phys_addr[PHYS_W-1 -: PAGE_W] == IO_PAGE)
      |-> region_sel == NUM_SEL'(1 << RGN_IO));

  assert_open_gap_R11: assert property (@(posedge clk) disable iff (rst)
    (primed && open_bus) |->
      (phys_addr[PHYS_W-1 -: PAGE_W] > EXP_HI_LAST &&
       phys_addr[PHYS_W-1 -: PAGE_W] < IO_PAGE));

  assert_sel_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    primed |-> $countones({open_bus, region_sel}) == 1);

endmodule

// File: tb/page_mmu_tb_top.sv
module page_mmu_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 15;

  // Entry: {page[7:0], window[2:0], offset[12:0], expected {open_bus, region_sel[4:0]}}
  localparam logic [29:0] VEC [NVEC] = '{
    {8'h00, 3'd7, 13'h1FFF, 6'b000001},
    {8'h7F, 3'd2, 13'h0000, 6'b000001},
    {8'h80, 3'd3, 13'h0ABC, 6'b000010},
    {8'hF7, 3'd4, 13'h1234, 6'b000010},
    {8'hF8, 3'd1, 13'h0000, 6'b000100},
    {8'hF8, 3'd1, 13'h01FF, 6'b000100},
    {8'hF9, 3'd5, 13'h0001, 6'b001000},
    {8'hFB, 3'd6, 13'h1F00, 6'b001000},
    {8'hFA, 3'd0, 13'h0777, 6'b001000},
    {8'hFC, 3'd2, 13'h0100, 6'b100000},
    {8'hFE, 3'd3, 13'h1555, 6'b100000},
    {8'hFF, 3'd0, 13'h0000, 6'b010000},
    {8'hFF, 3'd0, 13'h1FFF, 6'b010000},
    {8'h42, 3'd6, 13'h0AAA, 6'b000001},
    {8'hC3, 3'd5, 13'h1000, 6'b000010}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] log_addr = '0;
  logic        map_wr_en = 1'b0;
  logic [2:0]  map_idx = '0;
  logic [7:0]  map_wr_data = '0;
  logic [7:0]  map_rd_data;
  logic [20:0] phys_addr;
  logic [4:0]  region_sel;
  logic        open_bus;

  int vec_cnt = 0;
  int bad_cnt = 0;
  logic [7:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_mmu dut_i (
    .clk         (clk),
    .rst         (rst),
    .log_addr    (log_addr),
    .map_wr_en   (map_wr_en),
    .map_idx     (map_idx),
    .map_wr_data (map_wr_data),
    .map_rd_data (map_rd_data),
    .phys_addr   (phys_addr),
    .region_sel  (region_sel),
    .open_bus    (open_bus)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string region_tag(input logic [7:0] pg);
    if (pg <= 8'h7F) return "R6 cartridge";
    if (pg <= 8'hF7) return "R7 low expansion";
    if (pg == 8'hF8) return "R8 working RAM";
    if (pg <= 8'hFB) return "R9 high expansion";
    if (pg == 8'hFF) return "R10 io";
    return "R11 open bus";
  endfunction

  // Called at a falling edge; returns at the next falling edge with the register loaded.
  task automatic wr_map(input logic [2:0] idx, input logic [7:0] data);
    map_wr_en   = 1'b1;
    map_idx     = idx;
    map_wr_data = data;
    @(negedge clk);
    map_wr_en   = 1'b0;
    model[idx]  = data;
  endtask

  // Called at a falling edge; returns at the next falling edge with the result registered.
  task automatic xlate(input logic [15:0] a);
    log_addr = a;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    log_addr = 16'hE123;
    repeat (3) @(negedge clk);
    chk(phys_addr == 21'h0 && region_sel == 5'h0 && !open_bus && map_rd_data == 8'h0,
        "R5 outputs clear in reset", {phys_addr, region_sel, open_bus}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(phys_addr == 21'h000123, "R5 reset page is $00 in window 7", phys_addr, 21'h000123);
    chk({open_bus, region_sel} == 6'b000001, "R6 reset vector hits cartridge",
        {open_bus, region_sel}, 6'b000001);

    // Table walk.
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0]  pg;
      logic [2:0]  win;
      logic [12:0] off;
      logic [5:0]  esel;
      {pg, win, off, esel} = VEC[v];
      wr_map(win, pg);
      xlate({win, off});
      chk(phys_addr[12:0] == off, "R1 offset", phys_addr[12:0], off);
      chk(phys_addr[20:13] == pg, "R2 page", phys_addr[20:13], pg);
      chk({open_bus, region_sel} == esel, region_tag(pg), {open_bus, region_sel}, esel);
      chk($countones({open_bus, region_sel}) == 1, "R12 one select",
          {open_bus, region_sel}, esel);
    end

    // Read every register back.
    for (int i = 0; i < 8; i++) begin
      map_idx = 3'(i);
      @(negedge clk);
      chk(map_rd_data == model[i], "R4 read-back", map_rd_data, model[i]);
    end

    // A write takes effect for translation one cycle later.
    wr_map(3'd1, 8'h10);
    wr_map(3'd2, 8'h55);
    log_addr    = 16'h2005;
    map_wr_en   = 1'b1;
    map_idx     = 3'd1;
    map_wr_data = 8'hF8;
    @(negedge clk);
    map_wr_en = 1'b0;
    model[1]  = 8'hF8;
    chk(phys_addr == {8'h10, 13'h0005}, "R3 same-cycle address uses old page",
        phys_addr, {8'h10, 13'h0005});
    @(negedge clk);
    chk(phys_addr == {8'hF8, 13'h0005}, "R3 next cycle uses new page",
        phys_addr, {8'hF8, 13'h0005});
    chk({open_bus, region_sel} == 6'b000100, "R8 zero page through window 1",
        {open_bus, region_sel}, 6'b000100);
    xlate(16'h4321);
    chk(phys_addr[20:13] == 8'h55, "R3 other register untouched", phys_addr[20:13], 8'h55);

    // Read-back ordering around a write.
    map_idx = 3'd1;
    @(negedge clk);
    chk(map_rd_data == 8'hF8, "R4 read register 1", map_rd_data, 8'hF8);
    map_wr_en   = 1'b1;
    map_wr_data = 8'h33;
    @(negedge clk);
    map_wr_en = 1'b0;
    model[1]  = 8'h33;
    chk(map_rd_data == 8'hF8, "R4 same-cycle read returns old", map_rd_data, 8'hF8);
    @(negedge clk);
    chk(map_rd_data == 8'h33, "R4 next read returns new", map_rd_data, 8'h33);

    // Reset in mid-run clears all page registers.
    rst = 1'b1;
    @(negedge clk);
    chk(phys_addr == 21'h0 && !open_bus && region_sel == 5'h0, "R5 mid-run reset clears outputs",
        {phys_addr, region_sel, open_bus}, 32'h0);
    rst = 1'b0;
    map_idx = 3'd2;
    xlate(16'h4ABC);
    chk(phys_addr == {8'h00, 13'h0ABC}, "R5 register 2 back to $00", phys_addr, {8'h00, 13'h0ABC});
    chk(map_rd_data == 8'h00, "R5 read-back after reset", map_rd_data, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad_cnt++;
    vec_cnt++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

endmodule